// File: doc/BRIEF.md
# Clock-Source Change Lock Register

This block holds the clock-control fields of a microcontroller clock generator and guards them with a two-stage write protection. Four control registers carry the main-oscillator stop bit, the CPU clock source select, the divider and drive bits, the oscillation-stop detect enable and the PLL settings. A power-control register carries a sticky clock-lock bit. Once that bit is set, a fixed set of clock-control fields stops accepting writes. Only a reset releases the lock.

The power-control register itself accepts writes only while the write-enable bit of a separate protect register is open. The lock can be armed only while the main oscillator runs and is the CPU clock source. The procedure is: open the protect bit, write the lock bit, then close the protect bit. The lock never blocks a whole write. Each write is masked per bit, so unprotected bits in the same register stay writable.

All registers can be read over a simple synchronous bus at any time. A low-power wait request is filtered. While the lock is set, the request is withheld from the clock gating logic and an error flag is raised instead.

Top module: `clklock_top`

## Requirements
- R1: After reset, every register reads 0x00. This means the main oscillator is running and selected, the lock bit is 0 and the protect enable is 0.
- R2: Register map: 0 control-A, 1 control-B, 2 control-C, 3 PLL, 4 power-control, 5 protect. A write to power-control (address 4) has no effect while protect-register bit 0 is 0.
- R3: The lock bit is bit 0 of power-control. It becomes 1 only when all of the following hold at the same write:
  - 1 is written to it;
  - protect bit 0 is 1;
  - control-A bit 0 (oscillator stop) is 0;
  - control-A bit 1 (source select) is 0.

  Otherwise it stays 0. Bits 7:1 of power-control are still written whenever protect bit 0 is 1.
- R4: Once set, the lock bit stays 1 through any write and clears only on reset.
- R5: While locked, writes leave control-A bits 2:0 unchanged. Its bits 7:3 still take written data.
- R6: While locked, writes leave control-B bits 1:0 and control-C bit 0 unchanged. Their other bits still take written data.
- R7: While locked, no bit of the PLL register (address 3) can change.
- R8: Read data shows the addressed register in the same cycle, whatever the protect or lock state. Addresses 6 and 7 read 0x00. Protect-register bits 7:1 read 0.
- R9: With the lock clear, the wait output follows the wait request and the error flag is 0. With the lock set, the wait output is 0 and the error flag equals the wait request, in the same cycle.
- R10: While unlocked, every bit of control-A, control-B, control-C and PLL takes written data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rstN | input | 1 | Asynchronous active-low reset |
| we | input | 1 | Write strobe |
| addr | input | 3 | Register address |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data of the addressed register |
| waitReq | input | 1 | Low-power wait request from the core |
| waitGate | output | 1 | Wait request passed to clock gating |
| waitErr | output | 1 | Wait request refused because the clock is locked |

## Verification
The hardest state to reach from the ports is a refused lock attempt. In that case the protect bit is open and a 1 is written to the lock bit, but the oscillator stop or source select bit is 1. The write must still update the other power-control bits. The stimulus first sets both control-A bits with the lock clear, opens the protect bit and tries to lock. It then clears control-A and tries again, so that the refused and accepted paths differ only in the control-A state. After locking, the bench closes and reopens protection and writes all ones and all zeros to every register, to show the per-bit masks and the stickiness of the lock.

// File: rtl/clklock_pkg.sv
package clklock_pkg;
  parameter int DATA_W   = 8;
  parameter int ADDR_W   = 3;
  parameter int NUM_REGS = 6;

  localparam int IDX_CTLA = 0;
  localparam int IDX_CTLB = 1;
  localparam int IDX_CTLC = 2;
  localparam int IDX_PLL  = 3;
  localparam int IDX_PWR  = 4;
  localparam int IDX_PROT = 5;

  localparam int MAIN_STOP_BIT = 0;
  localparam int SRC_SEL_BIT   = 1;
  localparam int LOCK_BIT      = 0;
  localparam int PROT_EN_BIT   = 0;

  // Bits frozen while the clock lock is set
  localparam logic [DATA_W-1:0] FROZEN_CTLA = DATA_W'(8'h07);
  localparam logic [DATA_W-1:0] FROZEN_CTLB = DATA_W'(8'h03);
  localparam logic [DATA_W-1:0] FROZEN_CTLC = DATA_W'(8'h01);
  localparam logic [DATA_W-1:0] FROZEN_PLL  = {DATA_W{1'b1}};
  localparam logic [DATA_W-1:0] PROT_IMPL   = DATA_W'(1) << PROT_EN_BIT;
  localparam logic [DATA_W-1:0] LOCK_ONEHOT = DATA_W'(1) << LOCK_BIT;

  typedef struct packed {
    logic [NUM_REGS-1:0] wrSel;
    logic [DATA_W-1:0]   bitMask;
    logic                setLock;
  } wrStrobe_t;
endpackage

// File: rtl/clklock_ctrl.sv
module clklock_ctrl
  import clklock_pkg::*;
(
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              lockQ,
  input  logic              protEn,
  input  logic              mainStop,
  input  logic              srcSel,
  output wrStrobe_t         strobe
);
  logic [DATA_W-1:0] maskTable [NUM_REGS];

  always_comb begin
    maskTable[IDX_CTLA] = lockQ ? ~FROZEN_CTLA : '1;
    maskTable[IDX_CTLB] = lockQ ? ~FROZEN_CTLB : '1;
    maskTable[IDX_CTLC] = lockQ ? ~FROZEN_CTLC : '1;
    maskTable[IDX_PLL]  = lockQ ? ~FROZEN_PLL  : '1;
    maskTable[IDX_PWR]  = protEn ? ~LOCK_ONEHOT : '0;
    maskTable[IDX_PROT] = PROT_IMPL;
  end

  always_comb begin
    strobe = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (addr == ADDR_W'(i)) begin
        strobe.wrSel[i] = we;
        strobe.bitMask  = maskTable[i];
      end
    end
    // R3: arming needs the protect gate open and the main clock running and selected
    strobe.setLock = we && (addr == ADDR_W'(IDX_PWR)) && protEn &&
                     wrData[LOCK_BIT] && !mainStop && !srcSel;
  end
endmodule

// File: rtl/clklock_regs.sv
module clklock_regs
  import clklock_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  wrStrobe_t         strobe,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              waitReq,
  output logic [DATA_W-1:0] rdData,
  output logic              waitGate,
  output logic              waitErr,
  output logic              lockQ,
  output logic              protEn,
  output logic              mainStop,
  output logic              srcSel,
  output logic [DATA_W-1:0] ctlaView,
  output logic [DATA_W-1:0] ctlbView,
  output logic [DATA_W-1:0] ctlcView,
  output logic [DATA_W-1:0] pllView,
  output logic [DATA_W-1:0] pwrView
);
  logic [DATA_W-1:0] regQ [NUM_REGS];
  logic [DATA_W-1:0] readView [NUM_REGS];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_REGS; i++) regQ[i] <= '0;
    end else begin
      for (int i = 0; i < NUM_REGS; i++) begin
        if (strobe.wrSel[i])
          regQ[i] <= (regQ[i] & ~strobe.bitMask) | (wrData & strobe.bitMask);
      end
    end
  end

  // R4: sticky lock, only reset clears it
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               lockQ <= 1'b0;
    else if (strobe.setLock) lockQ <= 1'b1;
  end

  always_comb begin
    for (int i = 0; i < NUM_REGS; i++) readView[i] = regQ[i];
    readView[IDX_PWR] = (regQ[IDX_PWR] & ~LOCK_ONEHOT) | (lockQ ? LOCK_ONEHOT : '0);
  end

  always_comb begin
    rdData = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (addr == ADDR_W'(i)) rdData = readView[i];
  end

  assign protEn   = regQ[IDX_PROT][PROT_EN_BIT];
  assign mainStop = regQ[IDX_CTLA][MAIN_STOP_BIT];
  assign srcSel   = regQ[IDX_CTLA][SRC_SEL_BIT];
  assign ctlaView = regQ[IDX_CTLA];
  assign ctlbView = regQ[IDX_CTLB];
  assign ctlcView = regQ[IDX_CTLC];
  assign pllView  = regQ[IDX_PLL];
  assign pwrView  = readView[IDX_PWR];

  // R9: wait filter
  assign waitGate = waitReq & ~lockQ;
  assign waitErr  = waitReq & lockQ;
endmodule

// File: rtl/clklock_top.sv
module clklock_top
  import clklock_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic              waitReq,
  output logic              waitGate,
  output logic              waitErr
);
  wrStrobe_t         strobe;
  logic              lockQ, protEn, mainStop, srcSel;
  logic [DATA_W-1:0] ctlaView, ctlbView, ctlcView, pllView, pwrView;

  clklock_ctrl uCtrl (
    .we(we), .addr(addr), .wrData(wrData), .lockQ(lockQ), .protEn(protEn),
    .mainStop(mainStop), .srcSel(srcSel), .strobe(strobe)
  );

  clklock_regs uRegs (
    .clk(clk), .rstN(rstN), .strobe(strobe), .addr(addr), .wrData(wrData),
    .waitReq(waitReq), .rdData(rdData), .waitGate(waitGate), .waitErr(waitErr),
    .lockQ(lockQ), .protEn(protEn), .mainStop(mainStop), .srcSel(srcSel),
    .ctlaView(ctlaView), .ctlbView(ctlbView), .ctlcView(ctlcView),
    .pllView(pllView), .pwrView(pwrView)
  );
endmodule

// File: rtl/clklock_chk.sv
module clklock_chk
  import clklock_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              lockQ,
  input logic              protEn,
  input logic [DATA_W-1:0] ctlaView,
  input logic [DATA_W-1:0] ctlbView,
  input logic [DATA_W-1:0] ctlcView,
  input logic [DATA_W-1:0] pllView,
  input logic [DATA_W-1:0] pwrView,
  input logic              waitReq,
  input logic              waitGate,
  input logic              waitErr
);
  assert_lock_sticky_R4: assert property (@(posedge clk) disable iff (!rstN)
    lockQ |=> lockQ);

  assert_pwr_guard_R2: assert property (@(posedge clk) disable iff (!rstN)
    !protEn |=> $stable(pwrView));

  assert_lock_arm_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lockQ) |-> $past(protEn && !ctlaView[MAIN_STOP_BIT] && !ctlaView[SRC_SEL_BIT]));

  assert_ctla_frozen_R5: assert property (@(posedge clk) disable iff (!rstN)
    lockQ |=> ((ctlaView & FROZEN_CTLA) == $past(ctlaView & FROZEN_CTLA)));

  assert_ctlbc_frozen_R6: assert property (@(posedge clk) disable iff (!rstN)
    lockQ |=> (((ctlbView & FROZEN_CTLB) == $past(ctlbView & FROZEN_CTLB)) &&
               ((ctlcView & FROZEN_CTLC) == $past(ctlcView & FROZEN_CTLC))));

  assert_pll_frozen_R7: assert property (@(posedge clk) disable iff (!rstN)
    lockQ |=> $stable(pllView));

  assert_wait_block_R9: assert property (@(posedge clk) disable iff (!rstN)
    (waitReq && lockQ) |-> (waitErr && !waitGate));
endmodule

bind clklock_top clklock_chk uChk (
  .clk(clk), .rstN(rstN), .lockQ(lockQ), .protEn(protEn),
  .ctlaView(ctlaView), .ctlbView(ctlbView), .ctlcView(ctlcView),
  .pllView(pllView), .pwrView(pwrView),
  .waitReq(waitReq), .waitGate(waitGate), .waitErr(waitErr)
);

// File: tb/clklock_top_test.sv
`timescale 1ns/1ps
module clklock_top_test;
  logic       clk = 0;
  logic       rstN = 0;
  logic       we = 0;
  logic [2:0] addr = 0;
  logic [7:0] wrData = 0;
  logic       waitReq = 0;
  logic [7:0] rdData;
  logic       waitGate, waitErr;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;
  int model [0:7];

  always #2 clk = ~clk;

  clklock_top uut (
    .clk(clk), .rstN(rstN), .we(we), .addr(addr), .wrData(wrData),
    .rdData(rdData), .waitReq(waitReq), .waitGate(waitGate), .waitErr(waitErr)
  );

  function automatic bit locked();
    return model[4][0];
  endfunction

  task automatic check(string req, string what, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic modelWrite(int a, int d);
    int keep;
    case (a)
      0: begin keep = locked() ? 'h07 : 0; model[0] = (model[0] & keep) | (d & ~keep & 'hFF); end
      1: begin keep = locked() ? 'h03 : 0; model[1] = (model[1] & keep) | (d & ~keep & 'hFF); end
      2: begin keep = locked() ? 'h01 : 0; model[2] = (model[2] & keep) | (d & ~keep & 'hFF); end
      3: if (!locked()) model[3] = d & 'hFF;
      4: if (model[5][0]) begin
           bit lk;
           lk = locked() || (d[0] && (model[0] & 3) == 0);
           model[4] = (d & 'hFE) | int'(lk);
         end
      5: model[5] = d & 1;
      default: ;
    endcase
  endtask

  // One cycle: drive inputs, compare outputs mid-cycle, update model at the edge
  task automatic step(string req, bit w, int a, int d, bit wq);
    @(negedge clk);
    we = w; addr = 3'(a); wrData = 8'(d); waitReq = wq;
    #1;
    check(req, "rdData", rdData, model[a]);
    check("R9", "waitGate", waitGate, int'(wq && !locked()));
    check("R9", "waitErr", waitErr, int'(wq && locked()));
    @(posedge clk);
    if (w) modelWrite(a, d);
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 0; we = 0;
    for (int i = 0; i < 8; i++) model[i] = 0;
    @(negedge clk);
    rstN = 1;
  endtask

  initial begin
    #400000;
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    doReset();
    // R1: reset state of every register
    for (int i = 0; i < 8; i++) step("R1", 0, i, 0, 0);
    // R2: power-control write with protect closed
    step("R2", 1, 4, 'hFF, 1);
    step("R2", 0, 4, 0, 1);
    // R10: unlocked, all bits writable
    step("R10", 1, 1, 'hAA, 0);
    step("R10", 1, 2, 'h55, 0);
    step("R10", 1, 3, 'h5A, 0);
    step("R10", 1, 0, 'h03, 0);
    step("R10", 0, 1, 0, 0);
    step("R10", 0, 2, 0, 0);
    step("R10", 0, 3, 0, 0);
    step("R10", 0, 0, 0, 0);
    // R8: protect register upper bits read 0
    step("R8", 1, 5, 'hFF, 0);
    step("R8", 0, 5, 0, 0);
    // R3: refused arming (oscillator stopped / alt source), upper bits still written
    step("R3", 1, 4, 'h81, 0);
    step("R3", 0, 4, 0, 1);
    step("R3", 1, 0, 'h02, 0);
    step("R3", 1, 4, 'h41, 0);
    step("R3", 0, 4, 0, 0);
    // R3: accepted arming
    step("R3", 1, 0, 'h18, 0);
    step("R3", 1, 4, 'h01, 0);
    step("R3", 0, 4, 0, 1);
    step("R3", 1, 5, 'h00, 0);
    // R2/R4: closed protect, then reopened clear attempt
    step("R2", 1, 4, 'hF0, 0);
    step("R2", 0, 4, 0, 0);
    step("R4", 1, 5, 'h01, 0);
    step("R4", 1, 4, 'h00, 0);
    step("R4", 0, 4, 0, 1);
    // R5/R6/R7: per-bit masks while locked
    step("R5", 1, 0, 'hFF, 0);
    step("R5", 0, 0, 0, 0);
    step("R5", 1, 0, 'h00, 0);
    step("R5", 0, 0, 0, 0);
    step("R6", 1, 1, 'hFF, 0);
    step("R6", 0, 1, 0, 0);
    step("R6", 1, 2, 'h00, 0);
    step("R6", 0, 2, 0, 0);
    step("R7", 1, 3, 'hFF, 0);
    step("R7", 0, 3, 0, 0);
    step("R7", 1, 3, 'h00, 1);
    step("R7", 0, 3, 0, 0);
    // R8: unused addresses while locked
    step("R8", 1, 6, 'hFF, 0);
    step("R8", 0, 6, 0, 0);
    step("R8", 0, 7, 0, 0);
    // R4: reset releases the lock
    doReset();
    step("R4", 0, 4, 0, 1);
    step("R1", 0, 0, 0, 0);
    step("R1", 0, 3, 0, 0);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule